// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Lockdown

This block is a fully associative address translation buffer that is filled by software, one entry at a time. Software stages a tag word and then a translation word. A load command then commits both words into the slot that a replacement pointer names. A lock register holds a floor count, and the pointer never goes below it. The slots under the floor are therefore never replaced by the normal rotation.

Each entry has its own page size, so one buffer can hold 4 KB, 64 KB, 1 MB and 16 MB mappings side by side. The lookup port is combinational. It returns the physical address, with the low virtual bits that the page does not cover merged back in, and the page attributes. It reports a miss when no valid entry covers the address.

Two invalidation commands are provided. A targeted flush removes the entries that match the staged tag and size, and it also removes entries marked preserved. A global flush clears every entry except the preserved ones.

Top module: `swtlb`

## Requirements
- R1: Configuration writes use `cfg_sel` to pick the target. Code 0 stages the tag word, code 1 stages the translation word, code 2 writes the lock register, code 3 is load, code 4 is targeted flush and code 5 is global flush. In the tag word, bits 31:12 are the virtual tag, bit 3 is preserved, bit 2 is valid and bits 1:0 are the size code. In the translation word, bits 31:12 are the physical page, bit 9 is endianness, bits 8:7 are element size and bit 6 is the mixed-size select.
- R2: A load write with data bit 0 set copies both staged words into the entry at the current victim index. A load write with bit 0 clear changes neither the entries nor the victim index.
- R3: After each load the victim index advances by one. When it passes the last entry it wraps back to the locked base, so it never falls below the base.
- R4: A lock write takes the base from data bits 15:10 and the victim from bits 9:4. A base above NUM_ENTRIES-1 saturates to NUM_ENTRIES-1. A victim below the base, or at or above NUM_ENTRIES, is replaced by the base. `lock_word` shows the base in bits 15:10, the victim in bits 9:4 and zero in all other bits.
- R5: Matching is size-aware. Size code 3 (16 MB) compares VA[31:24], code 0 (1 MB) compares VA[31:20], code 1 (64 KB) compares VA[31:16] and code 2 (4 KB) compares VA[31:12].
- R6: On a hit, `lu_pa` takes the entry's physical page bits above the size boundary and the lookup VA bits below it. Bits 11:0 always come from the VA. The attribute outputs come from the hitting entry.
- R7: When no valid entry matches, `lu_hit` is 0 and `lu_pa` and all attribute outputs are 0.
- R8: An entry loaded with its valid bit clear never produces a hit.
- R9: A targeted flush write with bit 0 set invalidates every valid entry whose size code equals the staged size and whose tag equals the staged tag over that size's compared bits. Preserved entries are included. Entries of another size stay valid.
- R10: A global flush write with bit 0 set invalidates every entry that is not preserved, and leaves preserved entries valid.
- R11: When several entries match, the lowest-numbered entry supplies the result.
- R12: After reset all entries are invalid and the base and victim are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target code |
| cfg_wdata | input | 32 | Configuration write data |
| lock_word | output | 32 | Current base and victim index |
| lu_va | input | 32 | Lookup virtual address |
| lu_hit | output | 1 | Lookup found a valid match |
| lu_pa | output | 32 | Translated physical address |
| lu_endian | output | 1 | Endianness of the hitting page |
| lu_elsize | output | 2 | Element size of the hitting page |
| lu_mixed | output | 1 | Mixed-size select of the hitting page |

## Verification
The bench fills a small eight-entry buffer with one mapping of each page size and sweeps addresses that flip every single VA bit around each mapping. A compare mask that is off by one size step either hits outside the page or misses inside it, and a wrong merge puts physical bits where virtual bits belong. The victim pointer is driven through wrap, saturated base and out-of-range writes, where an unclamped pointer would overwrite locked slots. A small page is placed inside a 16 MB mapping to catch wrong priority. The two flush commands are run against preserved entries: a design that spares preserved entries on a targeted flush keeps a stale mapping, and one that clears them on a global flush loses a locked translation.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

  localparam int VPN_W   = 20;
  localparam int LOCK_FW = 6;

  typedef enum logic [1:0] {
    PG_SECT  = 2'd0,
    PG_LARGE = 2'd1,
    PG_SMALL = 2'd2,
    PG_SUPER = 2'd3
  } pg_size_e;

  typedef enum logic [2:0] {
    SEL_CAM      = 3'd0,
    SEL_RAM      = 3'd1,
    SEL_LOCK     = 3'd2,
    SEL_LOAD     = 3'd3,
    SEL_FLUSH1   = 3'd4,
    SEL_FLUSHALL = 3'd5
  } cfg_sel_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic             pres;
    logic             vld;
    logic [1:0]       size;
  } tag_ent_t;

  typedef struct packed {
    logic [VPN_W-1:0] ppn;
    logic             endian;
    logic [1:0]       elsize;
    logic             mixed;
  } xl_ent_t;

  function automatic tag_ent_t unpack_tag(input logic [31:0] w);
    tag_ent_t t;
    t.vpn  = w[31:12];
    t.pres = w[3];
    t.vld  = w[2];
    t.size = w[1:0];
    return t;
  endfunction

  function automatic xl_ent_t unpack_xl(input logic [31:0] w);
    xl_ent_t x;
    x.ppn    = w[31:12];
    x.endian = w[9];
    x.elsize = w[8:7];
    x.mixed  = w[6];
    return x;
  endfunction

  // Bits of the 20-bit page number that take part in the compare.
  function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    case (pg_size_e'(sz))
      PG_SUPER: m = 20'hFF000;
      PG_SECT:  m = 20'hFFF00;
      PG_LARGE: m = 20'hFFFF0;
      default:  m = 20'hFFFFF;
    endcase
    return m;
  endfunction

  function automatic logic tag_eq(input logic [VPN_W-1:0] a,
                                  input logic [VPN_W-1:0] b,
                                  input logic [1:0]       sz);
    return ((a ^ b) & vpn_mask(sz)) == '0;
  endfunction

  function automatic logic [VPN_W-1:0] merge_ppn(input logic [VPN_W-1:0] ppn,
                                                 input logic [VPN_W-1:0] vpn,
                                                 input logic [1:0]       sz);
    logic [VPN_W-1:0] m;
    m = vpn_mask(sz);
    return (ppn & m) | (vpn & ~m);
  endfunction

  function automatic logic [LOCK_FW-1:0] victim_fix(input logic [LOCK_FW-1:0] v,
                                                    input logic [LOCK_FW-1:0] b,
                                                    input int                 n);
    if (v < b || {1'b0, v} >= 7'(n)) return b;
    return v;
  endfunction

  function automatic logic [LOCK_FW-1:0] victim_next(input logic [LOCK_FW-1:0] v,
                                                     input logic [LOCK_FW-1:0] b,
                                                     input int                 n);
    logic [LOCK_FW:0] inc;
    inc = {1'b0, v} + 7'd1;
    if (inc >= 7'(n)) return b;
    return inc[LOCK_FW-1:0];
  endfunction

endpackage

// File: rtl/swtlb_regs.sv
module swtlb_regs
  import swtlb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         sel,
  input  logic [31:0]        wdata,
  output tag_ent_t           tag_stage,
  output xl_ent_t            xl_stage,
  output logic [LOCK_FW-1:0] base,
  output logic [LOCK_FW-1:0] victim,
  output logic               load_fire,
  output logic               flush_one_fire,
  output logic               flush_all_fire
);

  localparam logic [LOCK_FW-1:0] LAST = LOCK_FW'(N - 1);

  tag_ent_t           tag_q;
  xl_ent_t            xl_q;
  logic [LOCK_FW-1:0] base_q;
  logic [LOCK_FW-1:0] vic_q;
  logic [LOCK_FW-1:0] base_in;

  assign base_in = ({1'b0, wdata[15:10]} >= 7'(N)) ? LAST : wdata[15:10];

  assign load_fire      = we && (sel == SEL_LOAD)     && wdata[0];
  assign flush_one_fire = we && (sel == SEL_FLUSH1)   && wdata[0];
  assign flush_all_fire = we && (sel == SEL_FLUSHALL) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      xl_q   <= '0;
      base_q <= '0;
      vic_q  <= '0;
    end else if (we) begin
      case (sel)
        SEL_CAM:  tag_q <= unpack_tag(wdata);
        SEL_RAM:  xl_q  <= unpack_xl(wdata);
        SEL_LOCK: begin
          base_q <= base_in;
          vic_q  <= victim_fix(wdata[9:4], base_in, N);
        end
        SEL_LOAD: if (wdata[0]) vic_q <= victim_next(vic_q, base_q, N);
        default: ;
      endcase
    end
  end

  assign tag_stage = tag_q;
  assign xl_stage  = xl_q;
  assign base      = base_q;
  assign victim    = vic_q;

endmodule

// File: rtl/swtlb_store.sv
module swtlb_store
  import swtlb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_fire,
  input  logic               flush_one_fire,
  input  logic               flush_all_fire,
  input  logic [LOCK_FW-1:0] victim,
  input  tag_ent_t           tag_stage,
  input  xl_ent_t            xl_stage,
  output tag_ent_t           ent_tag [N],
  output xl_ent_t            ent_xl  [N],
  output logic [N-1:0]       valid_vec,
  output logic [N-1:0]       pres_vec,
  output logic [N-1:0]       flush_hit_vec
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    tag_ent_t t_q;
    xl_ent_t  x_q;
    logic     sel_me;

    assign sel_me = load_fire && (victim == LOCK_FW'(i));

    // Targeted flush ignores the preserved flag.
    assign flush_hit_vec[i] = t_q.vld && (t_q.size == tag_stage.size) &&
                              tag_eq(t_q.vpn, tag_stage.vpn, tag_stage.size);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_q <= '0;
        x_q <= '0;
      end else if (sel_me) begin
        t_q <= tag_stage;
        x_q <= xl_stage;
      end else if (flush_one_fire && flush_hit_vec[i]) begin
        t_q.vld <= 1'b0;
      end else if (flush_all_fire && !t_q.pres) begin
        t_q.vld <= 1'b0;
      end
    end

    assign ent_tag[i]   = t_q;
    assign ent_xl[i]    = x_q;
    assign valid_vec[i] = t_q.vld;
    assign pres_vec[i]  = t_q.pres;
  end

endmodule

// File: rtl/swtlb_match.sv
module swtlb_match
  import swtlb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [31:0]  va,
  input  tag_ent_t     ent_tag [N],
  input  xl_ent_t      ent_xl  [N],
  output logic [N-1:0] hit_vec,
  output logic         hit,
  output logic [31:0]  pa,
  output logic         endian,
  output logic [1:0]   elsize,
  output logic         mixed
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] win;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = ent_tag[i].vld && tag_eq(ent_tag[i].vpn, va[31:12], ent_tag[i].size);
  end

  // Lowest index wins: scan downward so the last assignment is the smallest.
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        win = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (hit) begin
      pa     = {merge_ppn(ent_xl[win].ppn, va[31:12], ent_tag[win].size), va[11:0]};
      endian = ent_xl[win].endian;
      elsize = ent_xl[win].elsize;
      mixed  = ent_xl[win].mixed;
    end else begin
      pa     = '0;
      endian = 1'b0;
      elsize = '0;
      mixed  = 1'b0;
    end
  end

endmodule

// File: rtl/swtlb.sv
module swtlb
  import swtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] lock_word,
  input  logic [31:0] lu_va,
  output logic        lu_hit,
  output logic [31:0] lu_pa,
  output logic        lu_endian,
  output logic [1:0]  lu_elsize,
  output logic        lu_mixed
);

  tag_ent_t                 tag_stage;
  xl_ent_t                  xl_stage;
  logic [LOCK_FW-1:0]       base;
  logic [LOCK_FW-1:0]       victim;
  logic                     load_fire;
  logic                     flush_one_fire;
  logic                     flush_all_fire;
  tag_ent_t                 ent_tag [NUM_ENTRIES];
  xl_ent_t                  ent_xl  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]   valid_vec;
  logic [NUM_ENTRIES-1:0]   pres_vec;
  logic [NUM_ENTRIES-1:0]   flush_hit_vec;
  logic [NUM_ENTRIES-1:0]   hit_vec;

  swtlb_regs #(.N(NUM_ENTRIES)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .we             (cfg_we),
    .sel            (cfg_sel),
    .wdata          (cfg_wdata),
    .tag_stage      (tag_stage),
    .xl_stage       (xl_stage),
    .base           (base),
    .victim         (victim),
    .load_fire      (load_fire),
    .flush_one_fire (flush_one_fire),
    .flush_all_fire (flush_all_fire)
  );

  swtlb_store #(.N(NUM_ENTRIES)) u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_fire      (load_fire),
    .flush_one_fire (flush_one_fire),
    .flush_all_fire (flush_all_fire),
    .victim         (victim),
    .tag_stage      (tag_stage),
    .xl_stage       (xl_stage),
    .ent_tag        (ent_tag),
    .ent_xl         (ent_xl),
    .valid_vec      (valid_vec),
    .pres_vec       (pres_vec),
    .flush_hit_vec  (flush_hit_vec)
  );

  swtlb_match #(.N(NUM_ENTRIES)) u_match (
    .va      (lu_va),
    .ent_tag (ent_tag),
    .ent_xl  (ent_xl),
    .hit_vec (hit_vec),
    .hit     (lu_hit),
    .pa      (lu_pa),
    .endian  (lu_endian),
    .elsize  (lu_elsize),
    .mixed   (lu_mixed)
  );

  assign lock_word = {16'd0, base, victim, 4'd0};

endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_fire,
  input logic         flush_one_fire,
  input logic         flush_all_fire,
  input logic [5:0]   victim,
  input logic [5:0]   base,
  input logic         staged_vld,
  input logic [N-1:0] valid_vec,
  input logic [N-1:0] pres_vec,
  input logic [N-1:0] flush_hit_vec,
  input logic         lu_hit,
  input logic [31:0]  lu_pa
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  p_victim_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (victim >= base) && ({1'b0, victim} < 7'(N)));

  p_victim_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> victim == (($past(victim) == 6'(N - 1)) ? $past(base) : $past(victim) + 6'd1));

  p_load_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> valid_vec[IDX_W'($past(victim))] == $past(staged_vld));

  p_flush_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_one_fire |=> (valid_vec & $past(flush_hit_vec)) == '0);

  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all_fire |=> (valid_vec & ~pres_vec) == '0);

  p_flush_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all_fire |=> (valid_vec & pres_vec) == $past(valid_vec & pres_vec));

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_hit |-> lu_pa == 32'd0);

endmodule

bind swtlb swtlb_chk #(.N(NUM_ENTRIES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .load_fire      (load_fire),
  .flush_one_fire (flush_one_fire),
  .flush_all_fire (flush_all_fire),
  .victim         (victim),
  .base           (base),
  .staged_vld     (tag_stage.vld),
  .valid_vec      (valid_vec),
  .pres_vec       (pres_vec),
  .flush_hit_vec  (flush_hit_vec),
  .lu_hit         (lu_hit),
  .lu_pa          (lu_pa)
);

// File: tb/sim_swtlb.sv
module sim_swtlb;

  localparam int CLK_NS = 10;
  localparam int N      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lock_word;
  logic [31:0] lu_va = '0;
  logic        lu_hit;
  logic [31:0] lu_pa;
  logic        lu_endian;
  logic [1:0]  lu_elsize;
  logic        lu_mixed;

  swtlb #(.NUM_ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lock_word(lock_word), .lu_va(lu_va),
    .lu_hit(lu_hit), .lu_pa(lu_pa), .lu_endian(lu_endian),
    .lu_elsize(lu_elsize), .lu_mixed(lu_mixed)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Reference state, updated from the requirements only.
  logic [31:0] m_tag [N];
  logic [31:0] m_xl  [N];
  logic [31:0] s_tag = '0;
  logic [31:0] s_xl  = '0;
  int          m_base = 0;
  int          m_vic  = 0;

  function automatic int kept_bits(input logic [1:0] sz);
    case (sz)
      2'd0: return 12;
      2'd1: return 16;
      2'd2: return 20;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] hi_mask(input logic [1:0] sz);
    return 32'hFFFF_FFFF << (32 - kept_bits(sz));
  endfunction

  function automatic logic [31:0] vbase(input int i);
    return (32'(i + 1) << 28) | 32'h0234_5000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input string req);
    logic        h;
    logic [31:0] p;
    logic [3:0]  a;
    h = 1'b0; p = '0; a = '0;
    lu_va = va;
    #1;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_tag[i][2] && (((va ^ m_tag[i]) & hi_mask(m_tag[i][1:0])) == 0)) begin
        h = 1'b1;
        p = (m_xl[i] & hi_mask(m_tag[i][1:0])) | (va & ~hi_mask(m_tag[i][1:0]));
        a = m_xl[i][9:6];
      end
    end
    chk(req, {27'd0, lu_hit, lu_endian, lu_elsize, lu_mixed, lu_pa}, {27'd0, h, a, p});
  endtask

  task automatic chk_lock(input string req);
    chk(req, {32'd0, lock_word}, {32'd0, (32'(m_base) << 10) | (32'(m_vic) << 4)});
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    int b;
    int v;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: s_tag = d;
      3'd1: s_xl = d;
      3'd2: begin
        b = int'(d[15:10]);
        if (b > N - 1) b = N - 1;
        v = int'(d[9:4]);
        if (v < b || v >= N) v = b;
        m_base = b; m_vic = v;
      end
      3'd3: if (d[0]) begin
        m_tag[m_vic] = s_tag; m_xl[m_vic] = s_xl;
        m_vic = (m_vic + 1 >= N) ? m_base : m_vic + 1;
      end
      3'd4: if (d[0]) begin
        for (int i = 0; i < N; i++)
          if (m_tag[i][2] && m_tag[i][1:0] == s_tag[1:0] &&
              (((m_tag[i] ^ s_tag) & hi_mask(s_tag[1:0])) == 0))
            m_tag[i][2] = 1'b0;
      end
      3'd5: if (d[0]) begin
        for (int i = 0; i < N; i++)
          if (!m_tag[i][3]) m_tag[i][2] = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic put(input logic [31:0] t, input logic [31:0] x);
    wr(3'd0, t);
    wr(3'd1, x);
    wr(3'd3, 32'd1);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 40; k++) begin
        logic [31:0] va;
        va = vbase(i) ^ (32'h1 << (k % 32)) ^ ((k >= 32) ? 32'h0000_0FFF : 32'h0);
        look(va, req);
      end
      look(vbase(i), req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_xl[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    chk_lock("R12 reset lock");
    look(32'h1234_5678, "R12 reset miss");
    look(32'h0000_0000, "R12 reset miss");

    // R1 R2 R3: fill every slot, one of each size, two preserved
    for (int i = 0; i < N; i++) begin
      put(vbase(i) | ((i == 1 || i == 5) ? 32'h8 : 32'h0) | 32'h4 | 32'(i % 4),
          (32'hA000_0000 ^ (32'(i) * 32'h0135_7000)) | (32'(i + 3) << 6));
      chk_lock("R3 victim advance");
    end

    // R5 R6: single-bit perturbation sweep around each mapping
    sweep("R5 R6 size-aware match and merge");

    // R7: pseudo-random addresses, mostly misses
    lf = 32'hACE1_2357;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      look(lf, "R7 miss outputs");
    end

    // R8: entry loaded invalid never hits
    wr(3'd2, 32'(2) << 4);
    chk_lock("R4 victim write");
    put(vbase(2) | 32'h2, 32'hDEAD_0000);
    look(vbase(2), "R8 invalid entry");
    look(vbase(2) + 32'h10, "R8 invalid entry");

    // R2: load with bit 0 clear is ignored
    wr(3'd0, vbase(3) | 32'h4 | 32'h2);
    wr(3'd3, 32'd0);
    chk_lock("R2 ignored load victim");
    look(vbase(3), "R2 ignored load entry");

    // R4: clamping and saturation
    wr(3'd2, (32'(3) << 10) | (32'(1) << 4));
    chk_lock("R4 victim below base");
    wr(3'd2, (32'(20) << 10) | (32'(0) << 4));
    chk_lock("R4 base saturates");
    put(32'h0F00_0004 | 32'h2, 32'h1111_1000);
    chk_lock("R3 wrap to base");
    look(32'h0F00_0123, "R3 load at saturated base");
    wr(3'd2, (32'(2) << 10) | (32'(9) << 4));
    chk_lock("R4 victim out of range");

    // R11: small page inside a 16 MB mapping, lower index wins
    wr(3'd2, 32'd0);
    chk_lock("R12 lock cleared");
    put(vbase(3) | 32'h4 | 32'h2, 32'h7770_0000 | (32'd5 << 6));
    look(vbase(3) | 32'h0ABC, "R11 lowest index wins");
    look(vbase(3) + 32'h1000, "R11 outside small page");
    look(vbase(3) + 32'h0010_0000, "R11 outside small page");

    // R9: targeted flush removes a preserved entry, not another size
    wr(3'd0, vbase(5) | (32'h1 << 12) | 32'(5 % 4));
    wr(3'd4, 32'd1);
    look(vbase(5), "R9 preserved entry flushed");
    wr(3'd0, vbase(6) | 32'h0);
    wr(3'd4, 32'd1);
    look(vbase(6), "R9 other size kept");
    look(vbase(6) + 32'h0000_0800, "R9 other size kept");

    // R10: global flush keeps preserved entries only
    wr(3'd5, 32'd1);
    look(vbase(1), "R10 preserved kept");
    sweep("R10 after global flush");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule